// File: doc/BRIEF.md
# Single-Byte-Addressed Two-Wire Memory Slave

This block is the bus-side controller of a small serial memory of 128 bytes. It listens on a two-wire bus made of a clock line (SCL) and an open-drain data line (SDA). Both lines are oversampled by the system clock. SDA is driven as an active-high output enable, and a driven line reads low. After a START, one byte selects the transfer. Its upper seven bits are the memory byte address and its least significant bit is the direction. No separate device-select byte is used.

On a write, the block acknowledges each data byte and collects it in a four-byte row latch. The two low address bits step and wrap inside the row. A STOP then starts the internal program cycle. The latched bytes leave on a valid/ready write stream towards the array, and a programming delay follows. The payload on that stream holds steady for as long as `pw_valid` is high and `pw_ready` is low. The array may stall the stream for any number of cycles. While the cycle runs, `busy` is high and the block stays off the bus. A master can therefore poll with START plus an address byte until it sees an acknowledge.

On a read, the block presents `rd_addr` and takes `rd_data` from the array combinationally. It shifts the byte out MSB first and releases the line for the master's acknowledge. It moves on to the next address for as long as the master keeps acknowledging. A write-control input blocks writes when it is seen high between the START and the end of the address byte.

Top module: `tw_mem_slave`

## Requirements
- R1: While reset is asserted, `sda_oe` is 0, `busy` is 0 and `pw_valid` is 0.
- R2: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. After a START, the first byte is taken MSB first on SCL rising edges. Its bits 7..1 are the byte address, and bit 0 gives the direction (1 = read, 0 = write).
- R3: When the block is not busy, it acknowledges the address byte by asserting `sda_oe` from the falling SCL edge after the eighth bit until the falling edge after the ninth.
- R4: In a write, each data byte is acknowledged and latched at the current address. After each byte only address bits 1..0 step up, and they wrap within the four-byte row. A later byte that lands on the same slot replaces the earlier one.
- R5: If `wc_i` is high at any time from the START through the eighth address bit, the address byte is still acknowledged. Data bytes are then not acknowledged and not latched, and the STOP starts no program cycle. Raising `wc_i` only after the address byte has no effect.
- R6: While `busy` is 1, the block never drives SDA and ignores START, STOP and data, so an address byte gets no acknowledge. Once `busy` has fallen, a fresh START plus address byte is acknowledged.
- R7: A STOP that ends a write with at least one latched byte raises `busy`. Every latched byte is sent on the write stream, then PROG_CYCLES clock cycles pass, and then `busy` falls. A STOP after a read, or after a write with no latched byte, leaves the block in standby with `busy` at 0.
- R8: In a read, each bit is driven while SCL is low, MSB first, from `rd_data` at `rd_addr`. SDA is released for the ninth clock. A master acknowledge (SDA low) continues the read at the next address, which wraps from 127 to 0. A master non-acknowledge ends the read, and SDA stays released until the next START.
- R9: A START in the middle of any transfer drops it and makes the block take a new address byte. A write dropped before any data byte latches nothing.
- R10: `pw_valid` is high only while `busy` is 1. While `pw_valid` is 1 and `pw_ready` is 0, `pw_valid`, `pw_addr` and `pw_data` hold. Each latched slot is sent exactly once at address {row, slot}.
- R11: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| wc_i | input | 1 | Write control, high blocks writes |
| busy | output | 1 | Internal program cycle in progress |
| rd_addr | output | 7 | Array read address |
| rd_data | input | 8 | Array read data for `rd_addr` |
| pw_valid | output | 1 | Write stream byte valid |
| pw_ready | input | 1 | Array accepts the write stream byte |
| pw_addr | output | 7 | Write stream byte address |
| pw_data | output | 8 | Write stream byte value |

## Verification
The bound checker watches four rules on every cycle. The line must stay quiet during a program cycle, the write stream must hold its payload under stall and appear only while busy, the output enable may change only with SCL low, and the outputs must be clear in reset. The directed scenarios cover the protocol-level behaviour that needs whole bus transfers to show. This includes row wrap with slot overwrite, write-control timing, and acknowledge polling during a program cycle. It also includes sequential reads across the 127-to-0 boundary and a START that cuts off a transfer. The array model receives the write stream under periodic back-pressure, and the bench reads its contents back over the bus to confirm them.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_WDATA, ST_RDATA, ST_MACK, ST_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    PG_IDLE, PG_DRAIN, PG_PROG
  } pg_st_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_proto_fsm.sv
module tw_proto_fsm
  import tw_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_s,
  input  logic          wc_s,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] rd_addr,
  output logic          pg_open,
  output logic [AW-IW-1:0] pg_row,
  output logic          pg_we,
  output logic [IW-1:0] pg_idx,
  output logic [DW-1:0] pg_data,
  output logic          pg_commit
);
  localparam int CNTW = $clog2(DW);
  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DW - 1);

  bus_st_e          st;
  logic [1:0]       ph;
  logic [CNTW-1:0]  cnt;
  logic [DW-1:0]    sh;
  logic [AW-1:0]    addr;
  logic             ack_en, after_rd, wc_seen, wr_sess;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= '0;
      cnt       <= '0;
      sh        <= '0;
      addr      <= '0;
      ack_en    <= 1'b0;
      after_rd  <= 1'b0;
      wc_seen   <= 1'b0;
      wr_sess   <= 1'b0;
      sda_oe    <= 1'b0;
      pg_open   <= 1'b0;
      pg_we     <= 1'b0;
      pg_idx    <= '0;
      pg_data   <= '0;
      pg_commit <= 1'b0;
    end else begin
      pg_open   <= 1'b0;
      pg_we     <= 1'b0;
      pg_commit <= 1'b0;
      if (busy) begin
        st      <= ST_IDLE;
        sda_oe  <= 1'b0;
        wr_sess <= 1'b0;
      end else if (start_ev) begin
        st      <= ST_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        wc_seen <= wc_s;
        wr_sess <= 1'b0;
      end else if (stop_ev) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        pg_commit <= wr_sess;
        wr_sess   <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (wc_s) wc_seen <= 1'b1;
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                st       <= ST_ACK;
                ph       <= 2'd0;
                ack_en   <= 1'b1;
                after_rd <= sda_s;
                addr     <= sh[AW-1:0];
                if (!sda_s) begin
                  wr_sess <= 1'b1;
                  pg_open <= 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (ph == 2'd0 && scl_fall) begin
              sda_oe <= ack_en;
              ph     <= 2'd1;
            end else if (ph == 2'd1 && scl_rise) begin
              ph <= 2'd2;
            end else if (ph == 2'd2 && scl_fall) begin
              cnt <= '0;
              if (after_rd) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[DW-1];
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                st     <= ST_ACK;
                ph     <= 2'd0;
                ack_en <= ~wc_seen;
                if (!wc_seen) begin
                  pg_we   <= 1'b1;
                  pg_data <= {sh[DW-2:0], sda_s};
                  pg_idx  <= addr[IW-1:0];
                  addr    <= {addr[AW-1:IW], addr[IW-1:0] + IW'(1)};
                end
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              sh     <= {sh[DW-2:0], 1'b0};
              sda_oe <= ~sh[DW-2];
            end else if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                st <= ST_MACK;
                ph <= 2'd0;
              end
            end
          end
          ST_MACK: begin
            if (ph == 2'd0 && scl_fall) begin
              sda_oe <= 1'b0;
              addr   <= addr + 1'b1;
              ph     <= 2'd1;
            end else if (ph == 2'd1 && scl_rise) begin
              if (!sda_s) ph <= 2'd2;
              else        st <= ST_SKIP;
            end else if (ph == 2'd2 && scl_fall) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              cnt    <= '0;
              st     <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = addr;
  assign pg_row  = addr[AW-1:IW];
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf
  import tw_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int PAGE        = 4,
  parameter int PROG_CYCLES = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_open,
  input  logic [AW-$clog2(PAGE)-1:0] pg_row,
  input  logic             pg_we,
  input  logic [$clog2(PAGE)-1:0] pg_idx,
  input  logic [DW-1:0]    pg_data,
  input  logic             pg_commit,
  output logic             busy,
  output logic             pw_valid,
  input  logic             pw_ready,
  output logic [AW-1:0]    pw_addr,
  output logic [DW-1:0]    pw_data
);
  localparam int IW = $clog2(PAGE);
  localparam int RW = AW - IW;
  localparam int CW = $clog2(PROG_CYCLES + 1);

  pg_st_e          pst;
  logic [RW-1:0]   row;
  logic [PAGE-1:0] mask;
  logic [DW-1:0]   slot [PAGE];
  logic [CW-1:0]   pcnt;
  logic [IW-1:0]   sel;

  always_comb begin
    sel = '0;
    for (int i = PAGE - 1; i >= 0; i--) begin
      if (mask[i]) sel = IW'(i);
    end
  end

  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot[g] <= '0;
        else if (pg_we && pg_idx == IW'(g)) slot[g] <= pg_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst  <= PG_IDLE;
      row  <= '0;
      mask <= '0;
      pcnt <= '0;
    end else begin
      unique case (pst)
        PG_IDLE: begin
          if (pg_open) begin
            mask <= '0;
            row  <= pg_row;
          end else if (pg_we) begin
            mask[pg_idx] <= 1'b1;
          end else if (pg_commit && |mask) begin
            pst <= PG_DRAIN;
          end
        end
        PG_DRAIN: begin
          if (mask == '0) begin
            pst  <= PG_PROG;
            pcnt <= '0;
          end else if (pw_ready) begin
            mask[sel] <= 1'b0;
          end
        end
        PG_PROG: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == CW'(PROG_CYCLES - 1)) pst <= PG_IDLE;
        end
        default: pst <= PG_IDLE;
      endcase
    end
  end

  assign busy     = (pst != PG_IDLE);
  assign pw_valid = (pst == PG_DRAIN) && (mask != '0);
  assign pw_addr  = {row, sel};
  assign pw_data  = slot[sel];
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int PAGE        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYCLES = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          wc_i,
  output logic          busy,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          pw_valid,
  input  logic          pw_ready,
  output logic [AW-1:0] pw_addr,
  output logic [DW-1:0] pw_data
);
  localparam int IW = $clog2(PAGE);

  logic [2:0] raw_l, syn_l;
  logic scl_s, sda_s, wc_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic pg_open, pg_we, pg_commit;
  logic [AW-IW-1:0] pg_row;
  logic [IW-1:0]    pg_idx;
  logic [DW-1:0]    pg_data;

  assign raw_l = {wc_i, sda_i, scl_i};

  tw_line_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_l), .q_o(syn_l)
  );

  assign scl_s = syn_l[0];
  assign sda_s = syn_l[1];
  assign wc_s  = syn_l[2];

  tw_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tw_proto_fsm #(.AW(AW), .DW(DW), .IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_s(sda_s), .wc_s(wc_s), .busy(busy), .rd_data(rd_data),
    .sda_oe(sda_oe), .rd_addr(rd_addr),
    .pg_open(pg_open), .pg_row(pg_row), .pg_we(pg_we),
    .pg_idx(pg_idx), .pg_data(pg_data), .pg_commit(pg_commit)
  );

  tw_page_buf #(.AW(AW), .DW(DW), .PAGE(PAGE), .PROG_CYCLES(PROG_CYCLES)) u_page (
    .clk(clk), .rst_n(rst_n),
    .pg_open(pg_open), .pg_row(pg_row), .pg_we(pg_we),
    .pg_idx(pg_idx), .pg_data(pg_data), .pg_commit(pg_commit),
    .busy(busy), .pw_valid(pw_valid), .pw_ready(pw_ready),
    .pw_addr(pw_addr), .pw_data(pw_data)
  );
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          busy,
  input logic          pw_valid,
  input logic          pw_ready,
  input logic [AW-1:0] pw_addr,
  input logic [DW-1:0] pw_data
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !busy && !pw_valid));

  // R6
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R10
  pw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && !pw_ready) |=> (pw_valid && $stable(pw_addr) && $stable(pw_data)));

  // R10
  pw_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid |-> busy);

  // R11
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));
endmodule

bind tw_mem_slave tw_mem_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .busy(busy),
  .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_addr(pw_addr), .pw_data(pw_data)
);

// File: tb/sim_tw_mem_slave.sv
module sim_tw_mem_slave;
  localparam int Q    = 10;
  localparam int PROG = 2000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wc = 1'b0;
  logic pw_ready = 1'b1;
  logic sda_oe, busy, pw_valid;
  logic [6:0] rd_addr, pw_addr;
  logic [7:0] rd_data, pw_data;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic sda_line;
  int checks = 0, errs = 0;
  int stall_viol = 0, stall_seen = 0, oe_viol = 0;
  logic [1:0] rc = '0;
  logic prev_stall = 1'b0, prev_oe = 1'b0;
  logic [6:0] prev_pa;
  logic [7:0] prev_pd;

  assign sda_line = sda_m & ~sda_oe;
  always_comb rd_data = mem[rd_addr];

  tw_mem_slave #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wc_i(wc), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_addr(pw_addr), .pw_data(pw_data)
  );

  always @(posedge clk) if (pw_valid && pw_ready) mem[pw_addr] <= pw_data;

  always @(negedge clk) begin
    rc = rc + 2'd1;
    pw_ready = (rc != 2'd3);
    if (prev_stall && (!pw_valid || pw_addr != prev_pa || pw_data != prev_pd)) stall_viol++;
    if (pw_valid && !pw_ready) stall_seen++;
    prev_stall = pw_valid && !pw_ready;
    prev_pa = pw_addr;
    prev_pd = pw_data;
    if (rst_n && sda_oe != prev_oe && scl_m) oe_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hq(); scl_m = 1'b1; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
    ack = ~sda_line;
    scl_m = 1'b0; hq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); scl_m = 1'b1; hq();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    hq(); sda_m = ~mack; hq(); scl_m = 1'b1; hq(); scl_m = 1'b0; hq(); sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 pw_valid in reset", pw_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_byte_write();
    logic a;
    bus_start();
    send_byte({7'h10, 1'b0}, a); chk("R3 address ack", a, 1);
    send_byte(8'h5A, a);         chk("R4 data ack", a, 1);
    bus_stop();
    repeat (6) @(negedge clk);
    chk("R7 busy after write stop", busy, 1);
    wait_idle();
    exp_mem[16] = 8'h5A;
    chk("R7 byte programmed", mem[16], exp_mem[16]);
  endtask

  task automatic t_poll();
    logic a;
    logic [7:0] d;
    int nacks = 0;
    bus_start();
    send_byte({7'h20, 1'b0}, a);
    send_byte(8'h11, a);
    bus_stop();
    exp_mem[32] = 8'h11;
    a = 1'b0;
    for (int k = 0; k < 60 && !a; k++) begin
      bus_start();
      send_byte({7'h20, 1'b1}, a);
      if (!a) begin
        nacks++;
        bus_stop();
      end
    end
    chk("R6 no ack while busy", nacks > 0, 1);
    chk("R6 ack after program cycle", a, 1);
    recv_byte(d, 1'b0);
    chk("R8 read after poll", d, exp_mem[32]);
    bus_stop();
  endtask

  task automatic t_page_roll();
    logic a;
    bus_start();
    send_byte({7'h0A, 1'b0}, a);
    for (int k = 0; k < 5; k++) begin
      send_byte(8'hA0 + 8'(k), a);
      chk("R4 page data ack", a, 1);
    end
    bus_stop();
    wait_idle();
    exp_mem[10] = 8'hA4; exp_mem[11] = 8'hA1; exp_mem[8] = 8'hA2; exp_mem[9] = 8'hA3;
    chk("R4 slot 2 overwritten", mem[10], exp_mem[10]);
    chk("R4 slot 3", mem[11], exp_mem[11]);
    chk("R4 wrap slot 0", mem[8], exp_mem[8]);
    chk("R4 wrap slot 1", mem[9], exp_mem[9]);
    chk("R4 row neighbour untouched", mem[12], exp_mem[12]);
  endtask

  task automatic t_wc_addr();
    logic a;
    bus_start();
    wc = 1'b1; hq(); wc = 1'b0;
    send_byte({7'h30, 1'b0}, a); chk("R5 address ack with wc", a, 1);
    send_byte(8'hEE, a);         chk("R5 data nack with wc", a, 0);
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R5 no program cycle", busy, 0);
    chk("R5 memory unchanged", mem[48], exp_mem[48]);
  endtask

  task automatic t_wc_data();
    logic a;
    bus_start();
    send_byte({7'h31, 1'b0}, a);
    wc = 1'b1;
    send_byte(8'h77, a); chk("R5 late wc still acks", a, 1);
    wc = 1'b0;
    bus_stop();
    wait_idle();
    exp_mem[49] = 8'h77;
    chk("R5 late wc still writes", mem[49], exp_mem[49]);
  endtask

  task automatic t_read_wrap();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({7'h7E, 1'b1}, a); chk("R3 read address ack", a, 1);
    recv_byte(d, 1'b1); chk("R2 addressed read byte", d, exp_mem[126]);
    recv_byte(d, 1'b1); chk("R8 increment", d, exp_mem[127]);
    recv_byte(d, 1'b0); chk("R8 wrap to 0", d, exp_mem[0]);
    hq();
    chk("R8 released after nack", sda_oe, 0);
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R7 read stop stays standby", busy, 0);
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] d;
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_start();
    send_byte({7'h0A, 1'b1}, a); chk("R9 ack after restart", a, 1);
    recv_byte(d, 1'b0);          chk("R9 read after restart", d, exp_mem[10]);
    bus_stop();
    bus_start();
    send_byte({7'h40, 1'b0}, a);
    put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte({7'h40, 1'b1}, a);
    recv_byte(d, 1'b0);
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R9 dropped write no cycle", busy, 0);
    chk("R9 dropped write no change", mem[64], exp_mem[64]);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 3 + 1);
      exp_mem[i] = 8'(i * 3 + 1);
    end
    t_reset();
    t_byte_write();
    t_poll();
    t_page_roll();
    t_wc_addr();
    t_wc_data();
    t_read_wrap();
    t_abort();
    chk("R10 stream held under stall", stall_viol, 0);
    chk("R10 stalls exercised", stall_seen > 0, 1);
    chk("R11 oe changes with scl low", oe_viol, 0);
    summary();
    $finish;
  end
endmodule